// File: doc/BRIEF.md
# Accumulator ALU with carry

An 8-bit arithmetic and logic unit that works on an accumulator and one carry flag. Each cycle the surrounding datapath presents an operation code, the present accumulator value, an already selected operand byte (register, immediate or memory data chosen outside this block) and the present carry. When the valid strobe is high, the block computes the next accumulator or destination byte and the next carry. It registers both values together with a write enable for each. The owner of the register file uses the enables to decide what to commit.

Only the carry flag is modelled. The operation set covers:
- add and add with carry
- subtract and subtract with borrow
- bitwise AND, compare and accumulator inversion
- increment and decrement of the operand
- forcing the carry high and flipping it

Codes with no assigned operation return the inputs unchanged with both enables low.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add) gives res_o = (acc_i + opnd_i) mod 256 and carry_o = 1 exactly when the unsigned sum exceeds 255. Both enables are 1.
- R2: Code 1 (add with carry) adds carry_i as a third addend. Result and carry follow the rule of R1, and both enables are 1.
- R3: Code 2 (subtract) gives res_o = (acc_i - opnd_i) mod 256. Code 3 (subtract with borrow) also subtracts carry_i. In both, carry_o = 1 exactly when the unsigned difference is negative, and both enables are 1.
- R4: Code 4 gives res_o = acc_i & opnd_i and carry_o = 0. Both enables are 1.
- R5: Code 5 (compare) gives res_o = acc_i with res_we_o = 0, and carry_o = (acc_i < opnd_i) unsigned with carry_we_o = 1.
- R6: Code 6 gives res_o = acc_i ^ 0xFF with res_we_o = 1. It returns carry_o = carry_i with carry_we_o = 0.
- R7: Code 7 gives res_o = (opnd_i + 1) mod 256 and code 8 gives res_o = (opnd_i - 1) mod 256, each with res_we_o = 1. Both return carry_o = carry_i with carry_we_o = 0.
- R8: Code 9 gives carry_o = 1 and code 10 gives carry_o = !carry_i, each with carry_we_o = 1. Both return res_o = acc_i with res_we_o = 0.
- R9: All four outputs are registers. They take the new values on the rising edge where valid_i is high and hold them while valid_i is low.
- R10: Codes 11 to 15 give res_o = acc_i and carry_o = carry_i, with both enables 0.
- R11: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Present accumulator |
| opnd_i | input | 8 | Selected operand byte |
| carry_i | input | 1 | Present carry |
| res_o | output | 8 | Registered result byte |
| carry_o | output | 1 | Registered next carry |
| res_we_o | output | 1 | Result write enable |
| carry_we_o | output | 1 | Carry write enable |

## Verification
The hardest cases sit at the edges of the carry chain. A borrow comes out of subtract with borrow only because of the incoming carry (equal operands with carry_i set). An add with carry reaches exactly 256 (0xFF plus 0x00 plus carry). The directed tasks set up these operands on purpose, and they also drive wrap-around values through increment and decrement. A separate hold scenario changes every input while valid_i is low and shows that the registered outputs do not move.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_CMP  = 4'd5,
    OP_NOT  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SETC = 4'd9,
    OP_TGLC = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {RES_ARITH, RES_LOGIC, RES_ACC} res_sel_e;
  typedef enum logic [2:0] {CY_ARITH, CY_ZERO, CY_ONE, CY_TGL, CY_KEEP} cy_sel_e;
  typedef enum logic [1:0] {LF_AND, LF_NOT, LF_INC, LF_DEC} logic_fn_e;

  typedef struct packed {
    res_sel_e  res_sel;
    cy_sel_e   cy_sel;
    logic_fn_e logic_fn;
    logic      sub;
    logic      cin_en;
    logic      res_we;
    logic      carry_we;
  } alu_ctrl_t;
endpackage

// File: rtl/acc_alu_dec.sv
module acc_alu_dec
  import acc_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{res_sel: RES_ACC, cy_sel: CY_KEEP, logic_fn: LF_AND,
               sub: 1'b0, cin_en: 1'b0, res_we: 1'b0, carry_we: 1'b0};
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        ctrl_o.res_sel  = RES_ARITH;
        ctrl_o.cy_sel   = CY_ARITH;
        ctrl_o.sub      = (op_i == OP_SUB) || (op_i == OP_SBC);
        ctrl_o.cin_en   = (op_i == OP_ADC) || (op_i == OP_SBC);
        ctrl_o.res_we   = 1'b1;
        ctrl_o.carry_we = 1'b1;
      end
      OP_AND: begin
        ctrl_o.res_sel  = RES_LOGIC;
        ctrl_o.logic_fn = LF_AND;
        ctrl_o.cy_sel   = CY_ZERO;
        ctrl_o.res_we   = 1'b1;
        ctrl_o.carry_we = 1'b1;
      end
      OP_CMP: begin
        ctrl_o.cy_sel   = CY_ARITH;
        ctrl_o.sub      = 1'b1;
        ctrl_o.carry_we = 1'b1;
      end
      OP_NOT: begin
        ctrl_o.res_sel  = RES_LOGIC;
        ctrl_o.logic_fn = LF_NOT;
        ctrl_o.res_we   = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctrl_o.res_sel  = RES_LOGIC;
        ctrl_o.logic_fn = (op_i == OP_INC) ? LF_INC : LF_DEC;
        ctrl_o.res_we   = 1'b1;
      end
      OP_SETC: begin
        ctrl_o.cy_sel   = CY_ONE;
        ctrl_o.carry_we = 1'b1;
      end
      OP_TGLC: begin
        ctrl_o.cy_sel   = CY_TGL;
        ctrl_o.carry_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned EW = W + 1;
  logic [EW-1:0] a_ext, b_ext, c_ext, full;

  assign a_ext = {1'b0, a_i};
  assign b_ext = {1'b0, b_i};
  assign c_ext = {{W{1'b0}}, cin_i};

  // Bit W is the carry on add and the borrow on subtract.
  always_comb begin
    if (sub_i) full = a_ext - b_ext - c_ext;
    else       full = a_ext + b_ext + c_ext;
  end

  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic_fn_e    fn_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    case (fn_i)
      LF_AND:  y_o = acc_i & opnd_i;
      LF_NOT:  y_o = ~acc_i;
      LF_INC:  y_o = opnd_i + ONE;
      default: y_o = opnd_i - ONE;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         res_we_o,
  output logic         carry_we_o
);
  alu_ctrl_t    ctrl;
  logic [W-1:0] arith_y, logic_y, res_d;
  logic         arith_c, carry_d;

  acc_alu_dec i_dec (
    .op_i  (op_i),
    .ctrl_o(ctrl)
  );

  acc_alu_arith #(.W(W)) i_arith (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (carry_i & ctrl.cin_en),
    .sub_i (ctrl.sub),
    .sum_o (arith_y),
    .cout_o(arith_c)
  );

  acc_alu_logic #(.W(W)) i_logic (
    .fn_i  (ctrl.logic_fn),
    .acc_i (acc_i),
    .opnd_i(opnd_i),
    .y_o   (logic_y)
  );

  always_comb begin
    case (ctrl.res_sel)
      RES_ARITH: res_d = arith_y;
      RES_LOGIC: res_d = logic_y;
      default:   res_d = acc_i;
    endcase
    case (ctrl.cy_sel)
      CY_ARITH: carry_d = arith_c;
      CY_ZERO:  carry_d = 1'b0;
      CY_ONE:   carry_d = 1'b1;
      CY_TGL:   carry_d = ~carry_i;
      default:  carry_d = carry_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o      <= '0;
      carry_o    <= 1'b0;
      res_we_o   <= 1'b0;
      carry_we_o <= 1'b0;
    end else if (valid_i) begin
      res_o      <= res_d;
      carry_o    <= carry_d;
      res_we_o   <= ctrl.res_we;
      carry_we_o <= ctrl.carry_we;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic         carry_i,
  input logic [W-1:0] res_o,
  input logic         carry_o,
  input logic         res_we_o,
  input logic         carry_we_o
);
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(carry_o) && $stable(res_we_o) && $stable(carry_we_o)); // R9

  AST_AND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_AND |=> !carry_o && carry_we_o && res_we_o); // R4

  AST_CMP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> !res_we_o && carry_we_o
      && res_o == $past(acc_i) && carry_o == ($past(acc_i) < $past(opnd_i))); // R5

  AST_NOT_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_NOT |=> !carry_we_o && carry_o == $past(carry_i)); // R6

  AST_INCDEC_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> !carry_we_o && carry_o == $past(carry_i)); // R7

  AST_SETC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SETC |=> carry_o && carry_we_o && !res_we_o); // R8

  AST_TGLC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_TGLC |=> carry_o == !$past(carry_i) && carry_we_o && !res_we_o); // R8

  AST_UNKNOWN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > 4'd10 |=> !res_we_o && !carry_we_o
      && res_o == $past(acc_i) && carry_o == $past(carry_i)); // R10
endmodule

bind acc_alu acc_alu_chk #(.W(W)) i_chk (.*);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic       carry_i = 1'b0;
  logic [7:0] res_o;
  logic       carry_o, res_we_o, carry_we_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  acc_alu i_acc_alu (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles", MAX_CYCLES);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Expected values built from the requirement text.
  function automatic void model(input logic [3:0] op, input logic [7:0] a, b, input logic c,
                                output logic [7:0] r, output logic rc, output logic rwe, cwe);
    int s;
    r = a; rc = c; rwe = 1'b0; cwe = 1'b0;
    case (op)
      4'd0: begin s = int'(a) + int'(b);           r = s[7:0]; rc = s > 255; rwe = 1; cwe = 1; end
      4'd1: begin s = int'(a) + int'(b) + int'(c); r = s[7:0]; rc = s > 255; rwe = 1; cwe = 1; end
      4'd2: begin s = int'(a) - int'(b);           r = s[7:0]; rc = s < 0;   rwe = 1; cwe = 1; end
      4'd3: begin s = int'(a) - int'(b) - int'(c); r = s[7:0]; rc = s < 0;   rwe = 1; cwe = 1; end
      4'd4: begin r = a & b; rc = 1'b0; rwe = 1; cwe = 1; end
      4'd5: begin rc = a < b; cwe = 1; end
      4'd6: begin r = a ^ 8'hFF; rwe = 1; end
      4'd7: begin r = b + 8'd1; rwe = 1; end
      4'd8: begin r = b - 8'd1; rwe = 1; end
      4'd9: begin rc = 1'b1; cwe = 1; end
      4'd10: begin rc = ~c; cwe = 1; end
      default: ;
    endcase
  endfunction

  task automatic compare(input string tag, input logic [7:0] er, input logic ec, erwe, ecwe);
    checks++;
    if (res_o !== er || carry_o !== ec || res_we_o !== erwe || carry_we_o !== ecwe) begin
      errors++;
      $display("FAIL %s: res=%h c=%b rwe=%b cwe=%b expected res=%h c=%b rwe=%b cwe=%b",
               tag, res_o, carry_o, res_we_o, carry_we_o, er, ec, erwe, ecwe);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [7:0] a, b, input logic c);
    logic [7:0] er;
    logic ec, erwe, ecwe;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; acc_i = a; opnd_i = b; carry_i = c;
    model(op, a, b, c, er, ec, erwe, ecwe);
    @(posedge clk_i);
    #1;
    compare(tag, er, ec, erwe, ecwe);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    compare("R11 reset", 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_add;
    run_op("R1 add no carry", 4'd0, 8'h12, 8'h34, 1'b1);
    run_op("R1 add overflow", 4'd0, 8'hF0, 8'h20, 1'b0);
    run_op("R1 add to 256", 4'd0, 8'h80, 8'h80, 1'b0);
  endtask

  task automatic t_adc;
    run_op("R2 adc 0xFF+0+1", 4'd1, 8'hFF, 8'h00, 1'b1);
    run_op("R2 adc no carry in", 4'd1, 8'hFF, 8'h00, 1'b0);
    run_op("R2 adc mid", 4'd1, 8'h3C, 8'h41, 1'b1);
  endtask

  task automatic t_sub;
    run_op("R3 sub borrow", 4'd2, 8'h10, 8'h20, 1'b0);
    run_op("R3 sub equal", 4'd2, 8'h55, 8'h55, 1'b1);
    run_op("R3 sbc borrow from carry", 4'd3, 8'h55, 8'h55, 1'b1);
    run_op("R3 sbc no borrow", 4'd3, 8'h90, 8'h0F, 1'b1);
  endtask

  task automatic t_and;
    run_op("R4 and clears carry", 4'd4, 8'hF3, 8'h3F, 1'b1);
  endtask

  task automatic t_cmp;
    run_op("R5 cmp less", 4'd5, 8'h01, 8'h02, 1'b0);
    run_op("R5 cmp equal", 4'd5, 8'h7E, 8'h7E, 1'b1);
    run_op("R5 cmp greater", 4'd5, 8'hFF, 8'h00, 1'b1);
  endtask

  task automatic t_not;
    run_op("R6 invert carry kept 1", 4'd6, 8'hA5, 8'h00, 1'b1);
    run_op("R6 invert carry kept 0", 4'd6, 8'h00, 8'hFF, 1'b0);
  endtask

  task automatic t_incdec;
    run_op("R7 inc wrap", 4'd7, 8'h00, 8'hFF, 1'b1);
    run_op("R7 inc", 4'd7, 8'h11, 8'h41, 1'b0);
    run_op("R7 dec wrap", 4'd8, 8'h22, 8'h00, 1'b0);
    run_op("R7 dec", 4'd8, 8'h22, 8'h80, 1'b1);
  endtask

  task automatic t_carry_ops;
    run_op("R8 set carry", 4'd9, 8'h5A, 8'h11, 1'b0);
    run_op("R8 toggle 0->1", 4'd10, 8'h5A, 8'h11, 1'b0);
    run_op("R8 toggle 1->0", 4'd10, 8'hC3, 8'h11, 1'b1);
  endtask

  task automatic t_unknown;
    for (int k = 11; k < 16; k++)
      run_op("R10 unknown code", 4'(k), 8'(k * 13), 8'hFF, k[0]);
  endtask

  task automatic t_hold;
    run_op("R9 load before hold", 4'd0, 8'hC8, 8'h64, 1'b0);
    @(negedge clk_i);
    op_i = 4'd9; acc_i = 8'h01; opnd_i = 8'h02; carry_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    compare("R9 hold while idle", 8'h2C, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_add();
    t_adc();
    t_sub();
    t_and();
    t_cmp();
    t_not();
    t_incdec();
    t_carry_ops();
    t_unknown();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule